// File: doc/BRIEF.md
# Event Interrupt Mask and ID Queue Controller

This block sits between an event arbiter and a processor core. Each cycle the arbiter may offer one granted event, as an index with a valid flag. The block checks the index against a per-event mask. If the event is unmasked and space is free, the index goes into a four-entry interrupt-ID queue. The main interrupt stays high while that queue holds anything. The core reads the oldest ID over APB. It removes that ID by acknowledging the interrupt with the one acknowledge ID that belongs to this block.

Per-event overflow pulses from the event queues outside the block set sticky error bits. Any of these bits raises a separate error interrupt. Any APB read access clears all error bits, so the handler that reads an error word also acknowledges it. A write-only register sends a one-cycle burst of software events. Two selector registers each route one event line to a timer output.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A register changes only in a cycle where psel, penable and pwrite are all high. A setup phase alone (psel without penable), or penable without psel, changes nothing.
- R2: Mask words sit at offset 0x04 + 4*w, for w = 0..7. Bit b of word w masks event 32*w + b, where 1 = blocked. All mask bits reset to 1, and mask words read back what was written.
- R3: When grant_vld_i is high and the mask bit for grant_idx_i is 0, grant_idx_i is pushed into the ID queue at that clock edge. A masked grant pushes nothing.
- R4: The queue holds 4 entries. grant_rdy_o is low exactly while 4 entries are held. A push offered then is dropped, even in a cycle that also pops.
- R5: irq_o is high exactly while the queue is non-empty. A read of offset 0x90 returns the oldest ID in bits 7:0, or 0 when the queue is empty. IDs leave in arrival order, and a read does not remove an entry.
- R6: The oldest entry is removed at a clock edge where core_ack_i is high and core_ack_id_i equals 3. An acknowledge with any other ID has no effect.
- R7: An ovf_i[i] pulse sets error bit i. Error word w at offset 0x64 + 4*w holds bit i = 32*w + b at bit b. Error bits are sticky, reset to 0, and ignore writes. err_irq_o is the OR of all error bits.
- R8: Any APB read access (psel, penable high, pwrite low) returns the current data and clears every error bit at that edge. An overflow pulse in the same cycle is still recorded.
- R9: A write to offset 0x00 drives pwdata[15:0] on sw_evt_o for exactly the one cycle after the write edge. sw_evt_o is 0 otherwise, and offset 0x00 reads as 0.
- R10: Selector A at 0x84 and selector B at 0x88 store pwdata[7:0] and reset to 0. timer_a_o and timer_b_o follow evt_lines_i at the selected index.
- R11: Offsets outside the map read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| paddr | input | 12 | APB byte address |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| grant_vld_i | input | 1 | Arbiter offers a granted event |
| grant_idx_i | input | 8 | Index of the granted event |
| grant_rdy_o | output | 1 | ID queue can accept a push |
| ovf_i | input | 256 | Per-event queue overflow pulses |
| evt_lines_i | input | 256 | Event lines available to the timer selectors |
| core_ack_i | input | 1 | Core interrupt acknowledge |
| core_ack_id_i | input | 5 | ID carried by the acknowledge |
| irq_o | output | 1 | Main interrupt, queue non-empty |
| err_irq_o | output | 1 | Error interrupt, any overflow bit set |
| sw_evt_o | output | 16 | One-cycle software event pulses |
| timer_a_o | output | 1 | Event routed by selector A |
| timer_b_o | output | 1 | Event routed by selector B |

## Verification
Some properties hold in every cycle, and the assertions check those. The queue count never passes four. A full queue stays full until a matching acknowledge. The interrupt cannot fall without a matching acknowledge. Error state persists until a read and is gone after a read that has no overflow beside it. The software-event outputs stay quiet unless offset 0x00 is written. Other behaviour can only be shown by the bench's scenarios: which mask bit covers which event index, the order in which IDs leave, the value a read returns, selector routing, and the absence of side effects from bus cycles that are incomplete or out of the map. The bench also runs a long random stream of grants and acknowledges against a queue model, which checks occupancy and the head ID in every cycle.

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int NEVT   = 256,
  parameter int FDEPTH = 4,
  parameter int ACKW   = 5,
  parameter int ACK_ID = 3,
  localparam int IDW   = $clog2(NEVT),
  localparam int NWORD = NEVT / 32,
  localparam int PW    = (FDEPTH > 1) ? $clog2(FDEPTH) : 1,
  localparam int CW    = $clog2(FDEPTH + 1)
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic [11:0]      paddr,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  input  logic             grant_vld_i,
  input  logic [IDW-1:0]   grant_idx_i,
  output logic             grant_rdy_o,
  input  logic [NEVT-1:0]  ovf_i,
  input  logic [NEVT-1:0]  evt_lines_i,
  input  logic             core_ack_i,
  input  logic [ACKW-1:0]  core_ack_id_i,
  output logic             irq_o,
  output logic             err_irq_o,
  output logic [15:0]      sw_evt_o,
  output logic             timer_a_o,
  output logic             timer_b_o
);
  localparam logic [11:0] A_SWEVT = 12'h000;
  localparam int          A_MASK  = 'h04;
  localparam int          A_ERR   = 'h64;
  localparam logic [11:0] A_SELA  = 12'h084;
  localparam logic [11:0] A_SELB  = 12'h088;
  localparam logic [11:0] A_FIFO  = 12'h090;

  logic [NEVT-1:0] mask_q, err_q;
  logic [IDW-1:0]  sel_a_q, sel_b_q;
  logic [15:0]     sw_q;
  logic [IDW-1:0]  fifo_q [FDEPTH];
  logic [PW-1:0]   wp_q, rp_q;
  logic [CW-1:0]   cnt_q;

  wire acc   = psel & penable;
  wire wr    = acc & pwrite;
  wire rd    = acc & ~pwrite;
  wire full  = cnt_q == CW'(FDEPTH);
  wire empty = cnt_q == '0;
  wire push  = grant_vld_i & ~mask_q[grant_idx_i] & ~full;
  wire pop   = core_ack_i & (core_ack_id_i == ACKW'(ACK_ID)) & ~empty;

  assign grant_rdy_o = ~full;
  assign irq_o       = ~empty;
  assign err_irq_o   = |err_q;
  assign sw_evt_o    = sw_q;
  assign timer_a_o   = evt_lines_i[sel_a_q];
  assign timer_b_o   = evt_lines_i[sel_b_q];

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      mask_q  <= '1;
      sel_a_q <= '0;
      sel_b_q <= '0;
      sw_q    <= '0;
    end else begin
      sw_q <= '0;
      if (wr) begin
        for (int w = 0; w < NWORD; w++)
          if (paddr == 12'(A_MASK + 4 * w)) mask_q[w*32 +: 32] <= pwdata;
        if (paddr == A_SELA)  sel_a_q <= pwdata[IDW-1:0];
        if (paddr == A_SELB)  sel_b_q <= pwdata[IDW-1:0];
        if (paddr == A_SWEVT) sw_q    <= pwdata[15:0];
      end
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) err_q <= '0;
    else          err_q <= rd ? ovf_i : (err_q | ovf_i);
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PW'(FDEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PW'(FDEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge pclk) begin
    if (push) fifo_q[wp_q] <= grant_idx_i;
  end

  always_comb begin
    prdata = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (paddr == 12'(A_MASK + 4 * w)) prdata = mask_q[w*32 +: 32];
      if (paddr == 12'(A_ERR + 4 * w))  prdata = err_q[w*32 +: 32];
    end
    if (paddr == A_SELA) prdata = 32'(sel_a_q);
    if (paddr == A_SELB) prdata = 32'(sel_b_q);
    if (paddr == A_FIFO && !empty) prdata = 32'(fifo_q[rp_q]);
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int NEVT   = 256,
  parameter int FDEPTH = 4,
  parameter int ACKW   = 5,
  parameter int ACK_ID = 3,
  localparam int CW    = $clog2(FDEPTH + 1)
) (
  input logic            pclk,
  input logic            presetn,
  input logic [11:0]     paddr,
  input logic            psel,
  input logic            penable,
  input logic            pwrite,
  input logic            grant_vld_i,
  input logic [NEVT-1:0] ovf_i,
  input logic            core_ack_i,
  input logic [ACKW-1:0] core_ack_id_i,
  input logic            irq_o,
  input logic            err_irq_o,
  input logic            grant_rdy_o,
  input logic [15:0]     sw_evt_o,
  input logic [CW-1:0]   cnt_q
);
  wire ack_hit = core_ack_i && core_ack_id_i == ACKW'(ACK_ID);
  wire bus_rd  = psel && penable && !pwrite;

  AST_CNT_BOUND: assert property (@(posedge pclk) disable iff (!presetn) cnt_q <= CW'(FDEPTH)); // R4
  AST_FULL_HOLDS: assert property (@(posedge pclk) disable iff (!presetn) (!grant_rdy_o && !ack_hit) |=> !grant_rdy_o); // R4
  AST_IRQ_NEEDS_ACK: assert property (@(posedge pclk) disable iff (!presetn) (irq_o && !ack_hit) |=> irq_o); // R6
  AST_IRQ_FROM_GRANT: assert property (@(posedge pclk) disable iff (!presetn) (!irq_o && !grant_vld_i) |=> !irq_o); // R3
  AST_ERR_STICKY: assert property (@(posedge pclk) disable iff (!presetn) (err_irq_o && !bus_rd) |=> err_irq_o); // R7
  AST_ERR_CLEARED: assert property (@(posedge pclk) disable iff (!presetn) (bus_rd && ovf_i == '0) |=> !err_irq_o); // R8
  AST_SW_QUIET: assert property (@(posedge pclk) disable iff (!presetn) !(psel && penable && pwrite && paddr == 12'h000) |=> sw_evt_o == '0); // R9
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .NEVT(NEVT), .FDEPTH(FDEPTH), .ACKW(ACKW), .ACK_ID(ACK_ID)
) u_chk (
  .pclk(pclk), .presetn(presetn), .paddr(paddr), .psel(psel), .penable(penable),
  .pwrite(pwrite), .grant_vld_i(grant_vld_i), .ovf_i(ovf_i), .core_ack_i(core_ack_i),
  .core_ack_id_i(core_ack_id_i), .irq_o(irq_o), .err_irq_o(err_irq_o),
  .grant_rdy_o(grant_rdy_o), .sw_evt_o(sw_evt_o), .cnt_q(cnt_q)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
  logic         pclk = 0, presetn = 0;
  logic [11:0]  paddr = '0;
  logic         psel = 0, penable = 0, pwrite = 0;
  logic [31:0]  pwdata = '0, prdata;
  logic         grant_vld_i = 0;
  logic [7:0]   grant_idx_i = '0;
  logic         grant_rdy_o;
  logic [255:0] ovf_i = '0, evt_lines_i = '0;
  logic         core_ack_i = 0;
  logic [4:0]   core_ack_id_i = '0;
  logic         irq_o, err_irq_o, timer_a_o, timer_b_o;
  logic [15:0]  sw_evt_o;

  int tests = 0, fails = 0;
  logic [255:0] mmask = '1;
  int q[$];

  always #10 pclk = ~pclk;

  evt_irq_ctrl u_evt_irq_ctrl (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] head_exp();
    return (q.size() == 0) ? 32'h0 : 32'(q[0]);
  endfunction

  function automatic logic exp_push(logic gv, logic [7:0] idx);
    return gv && !mmask[idx] && q.size() < 4;
  endfunction

  task automatic apb_wr(logic [11:0] a, logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic grant(logic [7:0] idx);
    @(negedge pclk); grant_vld_i = 1; grant_idx_i = idx;
    if (exp_push(1'b1, idx)) q.push_back(idx);
    @(negedge pclk); grant_vld_i = 0;
  endtask

  task automatic ack(logic [4:0] id);
    @(negedge pclk); core_ack_i = 1; core_ack_id_i = id;
    if (id == 5'd3 && q.size() > 0) void'(q.pop_front());
    @(negedge pclk); core_ack_i = 0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge pclk);
    presetn = 1;
    @(negedge pclk); #1;
    chk("R5 reset irq", irq_o, 0);
    chk("R7 reset err_irq", err_irq_o, 0);
    chk("R4 reset rdy", grant_rdy_o, 1);
    chk("R9 reset sw", sw_evt_o, 0);
    for (int w = 0; w < 8; w++) begin
      apb_rd(12'(4 + 4 * w), d); chk("R2 mask reset", d, 32'hFFFF_FFFF);
    end
    apb_rd(12'h084, d); chk("R10 sel a reset", d, 0);

    // R1: incomplete bus cycles
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h004; pwdata = 0;
    repeat (3) @(negedge pclk);
    psel = 0; penable = 1;
    repeat (2) @(negedge pclk);
    penable = 0; pwrite = 0;
    apb_rd(12'h004, d); chk("R1 no write without full access", d, 32'hFFFF_FFFF);

    // R3 masked grant / R2 bit mapping
    grant(8'd5); #1 chk("R3 masked grant no irq", irq_o, 0);
    apb_wr(12'h004, ~32'(1 << 5)); mmask[31:0] = ~32'(1 << 5);
    apb_rd(12'h004, d); chk("R2 mask readback", d, ~32'(1 << 5));
    grant(8'd5); #1 chk("R3 unmasked grant irq", irq_o, 1);
    paddr = 12'h090; #1 chk("R5 head id", prdata, 5);
    apb_wr(12'h008, ~32'(1 << 2)); mmask[63:32] = ~32'(1 << 2);
    grant(8'd34); grant(8'd33);
    apb_rd(12'h090, d); chk("R5 read keeps head", d, 5);
    ack(5'd2); #1 chk("R6 wrong id no pop", prdata, 5);
    ack(5'd3); paddr = 12'h090; #1 chk("R2 word1 bit2 is event 34", prdata, 34);
    ack(5'd3); #1 chk("R5 empty irq low", irq_o, 0);
    chk("R5 empty reads zero", prdata, 0);

    // R4 full queue
    apb_wr(12'h004, 32'h0); mmask[31:0] = '0;
    for (int i = 0; i < 4; i++) grant(8'(10 + i));
    #1 chk("R4 full rdy low", grant_rdy_o, 0);
    @(negedge pclk); grant_vld_i = 1; grant_idx_i = 8'd20; core_ack_i = 1; core_ack_id_i = 5'd3;
    void'(q.pop_front());
    @(negedge pclk); grant_vld_i = 0; core_ack_i = 0;
    for (int i = 0; i < 3; i++) begin
      paddr = 12'h090; #1 chk("R4 order after dropped push", prdata, 32'(11 + i));
      ack(5'd3);
    end
    #1 chk("R4 dropped push absent", irq_o, 0);
    q.delete();

    // R7 / R8 errors
    @(negedge pclk); ovf_i[40] = 1; @(negedge pclk); ovf_i = '0; #1;
    chk("R7 err irq set", err_irq_o, 1);
    apb_wr(12'h068, 32'h0);
    #1 chk("R7 write ignored", err_irq_o, 1);
    apb_rd(12'h068, d); chk("R7 error bit position", d, 32'(1 << 8));
    #1 chk("R8 cleared after read", err_irq_o, 0);
    apb_rd(12'h068, d); chk("R8 word zero", d, 0);
    @(negedge pclk); psel = 1; paddr = 12'h000;
    @(negedge pclk); penable = 1; ovf_i[3] = 1;
    @(negedge pclk); psel = 0; penable = 0; ovf_i = '0; #1;
    chk("R8 overflow beside read kept", err_irq_o, 1);
    apb_rd(12'h064, d); chk("R8 same-cycle bit", d, 32'h8);

    // R9 software events
    @(negedge pclk); psel = 1; pwrite = 1; paddr = 12'h000; pwdata = 32'hABCD_1234;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0; #1;
    chk("R9 sw pulse", sw_evt_o, 16'h1234);
    @(negedge pclk); #1 chk("R9 sw one cycle", sw_evt_o, 0);
    apb_rd(12'h000, d); chk("R9 reads zero", d, 0);

    // R10 timer selectors
    apb_wr(12'h084, 32'h1F7); apb_wr(12'h088, 32'h10);
    apb_rd(12'h084, d); chk("R10 sel a readback", d, 32'hF7);
    evt_lines_i = '0; evt_lines_i[247] = 1; #1;
    chk("R10 timer a", timer_a_o, 1); chk("R10 timer b", timer_b_o, 0);
    evt_lines_i = '0; evt_lines_i[16] = 1; #1;
    chk("R10 timer b follows", timer_b_o, 1); chk("R10 timer a low", timer_a_o, 0);

    // R11 undefined offsets
    apb_wr(12'h08C, 32'hFFFF_FFFF);
    apb_rd(12'h08C, d); chk("R11 undefined read", d, 0);
    apb_rd(12'h004, d); chk("R11 mask untouched", d, 0);
    apb_rd(12'h084, d); chk("R11 sel untouched", d, 32'hF7);

    // random traffic against queue model
    apb_wr(12'h004, 32'h5A3C_96E1); mmask[31:0] = 32'h5A3C_96E1;
    paddr = 12'h090;
    for (int n = 0; n < 1500; n++) begin
      logic gv, ak, p;
      logic [7:0] idx;
      logic [4:0] id;
      @(negedge pclk);
      gv = 1'($urandom);
      idx = 8'($urandom_range(0, 63));
      ak = ($urandom_range(0, 2) == 0);
      id = ($urandom_range(0, 1) == 0) ? 5'd3 : 5'($urandom);
      grant_vld_i = gv; grant_idx_i = idx; core_ack_i = ak; core_ack_id_i = id;
      #1;
      chk("R4 random rdy", grant_rdy_o, q.size() < 4);
      chk("R5 random irq", irq_o, q.size() > 0);
      chk("R3 random head", prdata, head_exp());
      p = exp_push(gv, idx);
      if (ak && id == 5'd3 && q.size() > 0) void'(q.pop_front());
      if (p) q.push_back(idx);
    end
    @(negedge pclk); grant_vld_i = 0; core_ack_i = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule